// File: doc/BRIEF.md
# DMA Bus Grant Arbiter

This block sits on the processor side of a shared system bus. It decides when an external direct-memory-access master may take the bus away from the local bus master. An external device raises a request line. The arbiter waits until the local master is between bus cycles and then drives a grant. The grant is passed down a priority daisy chain that lives outside this block, so it reaches the highest-priority requester.

The device that wins drops its request and raises an acknowledge. While that acknowledge is held, the device owns the bus and moves data without processor cycles. The arbiter withdraws the grant as soon as it sees the acknowledge. It then holds the local master off the bus until the acknowledge is released.

If the request disappears before any acknowledge arrives, the grant is withdrawn and the arbiter goes back to idle. The request and acknowledge lines come from other clock domains, so each passes through a synchronizer of `SYNC_STAGES` flops (default 2).

Top module: `dma_grant_arbiter`

## Requirements
- R1: After reset, `dma_grant_o` is 0 and `cyc_ok_o` is 1, so the processor owns the bus.
- R2: A request raised while the local master is idle produces `dma_grant_o` = 1 exactly `SYNC_STAGES`+1 clock edges after it is applied.
- R3: `dma_grant_o` rises only on an edge where `cyc_active_i` was 0. While the local master stays in a cycle the grant is held back, and it rises on the first edge after `cyc_active_i` falls.
- R4: `cyc_ok_o` falls `SYNC_STAGES` edges after a request is applied. It is never 1 while `dma_grant_o` is 1.
- R5: After an acknowledge is applied, `dma_grant_o` falls exactly `SYNC_STAGES`+1 edges later.
- R6: While the synchronized acknowledge is held after a grant, the arbiter stays in the device-owns-bus state with `dma_grant_o` = 0 and `cyc_ok_o` = 0, whatever the request line does.
- R7: After the acknowledge is released with no request pending, `cyc_ok_o` returns to 1 exactly `SYNC_STAGES`+1 edges later.
- R8: If the request is removed while the grant is out and no acknowledge has arrived, `dma_grant_o` falls `SYNC_STAGES`+1 edges later and `cyc_ok_o` returns to 1 on the same edge.
- R9: If a request is pending when ownership ends, the arbiter first returns to idle with `cyc_ok_o` = 0, and re-issues `dma_grant_o` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_req_i | input | 1 | Bus request from the DMA devices (asynchronous) |
| dma_ack_i | input | 1 | Bus-held acknowledge from the granted device (asynchronous) |
| cyc_active_i | input | 1 | Local bus master is inside a bus cycle |
| dma_grant_o | output | 1 | Grant into the priority daisy chain |
| cyc_ok_o | output | 1 | Local bus master may start a new cycle |

## Verification
Some properties are checked by assertions on every cycle:
- the grant never rises while the local master was mid-cycle;
- the grant never rises without a synchronized request;
- grant and cycle permission are never high together;
- ownership persists while the synchronized acknowledge is held;
- the grant drops after an acknowledge or after a withdrawn request.

The exact latencies through the synchronizers can only be shown by the bench scenarios, swept over busy-cycle and hold lengths. The same goes for the re-grant that follows back-to-back ownership.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_OWNED = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_arb_sync.sv
module dma_arb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] flops_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flops_q <= '0;
        else         flops_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flops_q <= '0;
        else         flops_q <= {flops_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = flops_q[STAGES-1];
endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic ack_s_i,
  input  logic cyc_active_i,
  output logic grant_o,
  output logic cyc_ok_o,
  output logic owned_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_s_i && !cyc_active_i) state_d = ST_GRANT;
      // acknowledge wins over a simultaneous request drop
      ST_GRANT: if (ack_s_i)                  state_d = ST_OWNED;
                else if (!req_s_i)            state_d = ST_IDLE;
      ST_OWNED: if (!ack_s_i)                 state_d = ST_IDLE;
      default:                                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign grant_o  = (state_q == ST_GRANT);
  assign owned_o  = (state_q == ST_OWNED);
  assign cyc_ok_o = (state_q == ST_IDLE) && !req_s_i;
endmodule

// File: rtl/dma_grant_arbiter.sv
module dma_grant_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_req_i,
  input  logic dma_ack_i,
  input  logic cyc_active_i,
  output logic dma_grant_o,
  output logic cyc_ok_o
);
  localparam int NSYNC = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic req_s, ack_s, owned;

  dma_arb_sync #(.STAGES(NSYNC)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dma_req_i), .q_o(req_s)
  );

  dma_arb_sync #(.STAGES(NSYNC)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dma_ack_i), .q_o(ack_s)
  );

  dma_arb_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_s_i     (req_s),
    .ack_s_i     (ack_s),
    .cyc_active_i(cyc_active_i),
    .grant_o     (dma_grant_o),
    .cyc_ok_o    (cyc_ok_o),
    .owned_o     (owned)
  );
endmodule

// File: rtl/dma_grant_arbiter_chk.sv
module dma_grant_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cyc_active_i,
  input logic dma_grant_o,
  input logic cyc_ok_o,
  input logic req_s,
  input logic ack_s,
  input logic owned
);
  p_grant_bus_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_grant_o) |-> !$past(cyc_active_i));

  p_grant_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_grant_o) |-> $past(req_s));

  p_no_start_in_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_grant_o |-> !cyc_ok_o);

  p_grant_drop_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_grant_o && ack_s) |=> (!dma_grant_o && owned));

  p_hold_owned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned && ack_s) |=> (owned && !dma_grant_o && !cyc_ok_o));

  p_withdraw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_grant_o && !req_s && !ack_s) |=> (!dma_grant_o && cyc_ok_o));
endmodule

bind dma_grant_arbiter dma_grant_arbiter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_active_i(cyc_active_i),
  .dma_grant_o (dma_grant_o),
  .cyc_ok_o    (cyc_ok_o),
  .req_s       (req_s),
  .ack_s       (ack_s),
  .owned       (owned)
);

// File: tb/dma_grant_arbiter_tb.sv
module dma_grant_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSYNC = 2;
  localparam int LAT = NSYNC + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dma_req_i = 1'b0;
  logic dma_ack_i = 1'b0;
  logic cyc_active_i = 1'b0;
  logic dma_grant_o, cyc_ok_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_grant_arbiter #(.SYNC_STAGES(NSYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dma_req_i(dma_req_i), .dma_ack_i(dma_ack_i),
    .cyc_active_i(cyc_active_i), .dma_grant_o(dma_grant_o), .cyc_ok_o(cyc_ok_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step(1);
    chk("R1 grant", dma_grant_o, 1'b0);
    chk("R1 cyc_ok", cyc_ok_o, 1'b1);

    // sweep: busy cycles d, ownership length hl
    for (int d = 0; d < 5; d++) begin
      for (int hl = 1; hl < 5; hl++) begin
        cyc_active_i = (d > 0);
        dma_req_i = 1'b1;
        step(NSYNC);
        chk("R4 cyc_ok low", cyc_ok_o, 1'b0);
        chk("R2 no early grant", dma_grant_o, 1'b0);
        for (int i = 0; i < d; i++) begin
          chk("R3 held while busy", dma_grant_o, 1'b0);
          step(1);
        end
        cyc_active_i = 1'b0;
        step(1);
        chk(d == 0 ? "R2 grant latency" : "R3 grant after busy", dma_grant_o, 1'b1);
        chk("R4 no start in grant", cyc_ok_o, 1'b0);
        dma_ack_i = 1'b1;
        dma_req_i = 1'b0;
        step(NSYNC);
        chk("R5 grant kept", dma_grant_o, 1'b1);
        step(1);
        chk("R5 grant dropped", dma_grant_o, 1'b0);
        for (int i = 0; i < hl; i++) begin
          cyc_active_i = i[0];
          chk("R6 stalled", cyc_ok_o, 1'b0);
          chk("R6 no grant", dma_grant_o, 1'b0);
          step(1);
        end
        cyc_active_i = 1'b0;
        dma_ack_i = 1'b0;
        step(NSYNC);
        chk("R7 still stalled", cyc_ok_o, 1'b0);
        step(1);
        chk("R7 released", cyc_ok_o, 1'b1);
        step(2);
      end
    end

    // withdraw before acknowledge
    for (int w = 0; w < 4; w++) begin
      dma_req_i = 1'b1;
      step(LAT);
      chk("R8 grant up", dma_grant_o, 1'b1);
      step(w);
      dma_req_i = 1'b0;
      step(NSYNC);
      chk("R8 grant kept", dma_grant_o, 1'b1);
      step(1);
      chk("R8 grant withdrawn", dma_grant_o, 1'b0);
      chk("R8 cyc_ok back", cyc_ok_o, 1'b1);
      step(2);
    end

    // second request raised during ownership
    for (int hl = 1; hl < 4; hl++) begin
      dma_req_i = 1'b1;
      step(LAT);
      chk("R9 first grant", dma_grant_o, 1'b1);
      dma_ack_i = 1'b1;
      dma_req_i = 1'b0;
      step(LAT);
      dma_req_i = 1'b1;
      step(hl + NSYNC);
      chk("R6 request ignored", dma_grant_o, 1'b0);
      chk("R6 still stalled", cyc_ok_o, 1'b0);
      dma_ack_i = 1'b0;
      step(LAT);
      chk("R9 idle no grant", dma_grant_o, 1'b0);
      chk("R9 idle cyc_ok low", cyc_ok_o, 1'b0);
      step(1);
      chk("R9 re-grant", dma_grant_o, 1'b1);
      dma_req_i = 1'b0;
      step(LAT);
      chk("R8 cleanup", dma_grant_o, 1'b0);
      step(2);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule